// File: doc/BRIEF.md
# SONET/SDH Receive Byte Aligner

This block turns a bit-serial SONET/SDH receive stream into aligned bytes. Bits arrive on a bit-rate clock with the most significant bit of each byte first. The block counts bit times modulo eight to make a byte strobe. It keeps the last six bytes' worth of bits in a shift window, so it can recognise the framing sequence (three A1 bytes, then three A2 bytes) at any bit rotation.

The byte boundary only moves when the link layer asks for it. A rising edge on the out-of-frame request starts a search. During the search the window is compared with the framing sequence on every bit clock, which covers all eight rotations once per byte period. The first rotation that completes the sequence becomes the new boundary, and the sync pulse is issued. After that the boundary stays fixed. It is not moved again until another rising edge arrives, even if framing bytes show up at other offsets.

The frame sync output is raised whenever the sequence ends on the current boundary, whatever the out-of-frame level. A hold input suppresses searching and keeps the present boundary.

Top module: `sonet_byte_aligner`

## Requirements
- R1: The first serial bit of each byte lands in byte_out bit 7, and byte_out bit 0 is the least significant (last received) bit.
- R2: While the boundary is not moved, byte_stb is high for one bit clock in every eight, and byte_out changes only on those cycles.
- R3: A1 is 8'hF6 and A2 is 8'h28. The framing sequence is A1, A1, A1, A2, A2, A2 on consecutive bytes, and a sync pulse is only issued with the final A2 on byte_out.
- R4: When the framing sequence completes on the current boundary, frame_sync rises with that byte's strobe and stays high for exactly eight bit clocks. This holds whether oof_req is high or low.
- R5: A search starts only on a low-to-high transition of oof_req. Holding oof_req high does not start a new search.
- R6: During a search the window is tested on every bit clock, so all eight rotations are covered. On the first match the boundary is set to that bit position: the final A2 is strobed out in the same cycle, and the next byte follows eight bit clocks later.
- R7: Outside a search the boundary never moves, even if the framing sequence appears at another bit offset.
- R8: While hold_align is high, no search is active, and an oof_req rising edge is ignored.
- R9: Reset clears the shift window, the bit-phase counter, byte_out, byte_stb and frame_sync, ends any search, and sets the boundary so that the first bit clock after reset starts a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_bit | input | 1 | Serial receive data, MSB of each byte first |
| oof_req | input | 1 | Out-of-frame request; a rising edge starts a boundary search |
| hold_align | input | 1 | When high, searching is suppressed and the boundary is held |
| byte_out | output | 8 | Aligned parallel byte |
| byte_stb | output | 1 | One-cycle strobe marking a new byte_out value |
| frame_sync | output | 1 | High for one byte period after a framing sequence on the boundary |

## Verification
The assertions assume that oof_req and hold_align are synchronous to the bit clock. They also assume oof_req is low while reset is asserted, so the edge detector does not see a false rising edge when reset is released. The bench changes every input just after the falling clock edge and keeps oof_req low through each reset. It places framing sequences both on and off the locked boundary, with the out-of-frame request held high and held low, so that the edge-only search rule and the level-independent sync rule are each exercised.

// File: rtl/sba_pkg.sv
package sba_pkg;
  localparam int unsigned SBA_BYTE_W = 8;
  localparam int unsigned SBA_A1_N   = 3;
  localparam int unsigned SBA_A2_N   = 3;
  localparam logic [7:0]  SBA_A1_DEF = 8'hF6;
  localparam logic [7:0]  SBA_A2_DEF = 8'h28;

  typedef enum logic {
    ST_LOCKED = 1'b0,
    ST_SEARCH = 1'b1
  } align_st_t;
endpackage

// File: rtl/sba_shift_window.sv
module sba_shift_window #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned A1_N   = 3,
  parameter int unsigned A2_N   = 3,
  parameter logic [BYTE_W-1:0] A1_VAL = 8'hF6,
  parameter logic [BYTE_W-1:0] A2_VAL = 8'h28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  output logic [BYTE_W-1:0] win_byte,
  output logic              pat_hit
);
  localparam int unsigned SLOTS = A1_N + A2_N;
  localparam int unsigned WIN_W = SLOTS * BYTE_W;

  // Oldest byte sits at the top of the window, newest at the bottom.
  function automatic logic [WIN_W-1:0] build_pattern();
    logic [WIN_W-1:0] p;
    p = '0;
    for (int s = 0; s < int'(SLOTS); s++) begin
      p[WIN_W-1-s*BYTE_W -: BYTE_W] = (s < int'(A1_N)) ? A1_VAL : A2_VAL;
    end
    return p;
  endfunction

  localparam logic [WIN_W-1:0] PATTERN = build_pattern();

  logic [WIN_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[WIN_W-2:0], bit_in};
  end

  assign win_byte = shreg[BYTE_W-1:0];
  assign pat_hit  = (shreg == PATTERN);
endmodule

// File: rtl/sba_align_ctrl.sv
module sba_align_ctrl
  import sba_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic oof_req,
  input  logic hold_align,
  input  logic pat_hit,
  output logic byte_edge,
  output logic frame_edge,
  output logic searching
);
  localparam int unsigned PH_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(BYTE_W - 1);

  function automatic logic [PH_W-1:0] next_phase(input logic [PH_W-1:0] p);
    return (p == PH_LAST) ? '0 : p + 1'b1;
  endfunction

  align_st_t       st;
  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] boff;
  logic            oof_q;
  logic            oof_rise;
  logic            relock;
  logic            on_boundary;

  assign oof_rise    = oof_req & ~oof_q;
  assign searching   = (st == ST_SEARCH);
  assign relock      = searching & pat_hit & ~hold_align;
  assign on_boundary = (phase == boff);
  assign byte_edge   = on_boundary | relock;
  assign frame_edge  = byte_edge & pat_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_LOCKED;
      phase <= '0;
      boff  <= '0;
      oof_q <= 1'b0;
    end else begin
      phase <= next_phase(phase);
      oof_q <= oof_req;
      if (hold_align) begin
        st <= ST_LOCKED;
      end else if (relock) begin
        st   <= ST_LOCKED;
        boff <= phase;
      end else if (oof_rise) begin
        st <= ST_SEARCH;
      end
    end
  end

  AST_LOCKED_BOFF_STABLE: assert property (@(posedge clk) disable iff (rst)
    !searching |=> $stable(boff)); // R7
  AST_SEARCH_NEEDS_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(searching) |-> $past(oof_req) && !$past(oof_q)); // R5
  AST_HOLD_BLOCKS_SEARCH: assert property (@(posedge clk) disable iff (rst)
    hold_align |=> !searching); // R8
  AST_MATCH_ENDS_SEARCH: assert property (@(posedge clk) disable iff (rst)
    (searching && pat_hit && !hold_align) |=> !searching); // R6
endmodule

// File: rtl/sba_byte_out.sv
module sba_byte_out #(
  parameter int unsigned BYTE_W = 8,
  parameter logic [BYTE_W-1:0] A2_VAL = 8'h28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_edge,
  input  logic              frame_edge,
  input  logic [BYTE_W-1:0] win_byte,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_stb,
  output logic              frame_sync
);
  always_ff @(posedge clk) begin
    if (rst) begin
      byte_out   <= '0;
      byte_stb   <= 1'b0;
      frame_sync <= 1'b0;
    end else begin
      byte_stb <= byte_edge;
      if (byte_edge) begin
        byte_out   <= win_byte;
        frame_sync <= frame_edge;
      end
    end
  end

  AST_SYNC_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_sync) |-> byte_stb); // R4
  AST_SYNC_HOLDS_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    !byte_stb |-> $stable(frame_sync)); // R4
  AST_BYTE_HOLDS_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    !byte_stb |-> $stable(byte_out)); // R2
  AST_SYNC_CARRIES_A2: assert property (@(posedge clk) disable iff (rst)
    (frame_sync && byte_stb) |-> byte_out == A2_VAL); // R3
endmodule

// File: rtl/sonet_byte_aligner.sv
module sonet_byte_aligner
  import sba_pkg::*;
#(
  parameter int unsigned BYTE_W = SBA_BYTE_W,
  parameter int unsigned A1_N   = SBA_A1_N,
  parameter int unsigned A2_N   = SBA_A2_N,
  parameter logic [BYTE_W-1:0] A1_VAL = SBA_A1_DEF,
  parameter logic [BYTE_W-1:0] A2_VAL = SBA_A2_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_bit,
  input  logic              oof_req,
  input  logic              hold_align,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_stb,
  output logic              frame_sync
);
  logic [BYTE_W-1:0] win_byte;
  logic              pat_hit;
  logic              byte_edge;
  logic              frame_edge;
  logic              searching;

  sba_shift_window #(
    .BYTE_W (BYTE_W),
    .A1_N   (A1_N),
    .A2_N   (A2_N),
    .A1_VAL (A1_VAL),
    .A2_VAL (A2_VAL)
  ) win_i (
    .clk      (clk),
    .rst      (rst),
    .bit_in   (rx_bit),
    .win_byte (win_byte),
    .pat_hit  (pat_hit)
  );

  sba_align_ctrl #(
    .BYTE_W (BYTE_W)
  ) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .oof_req    (oof_req),
    .hold_align (hold_align),
    .pat_hit    (pat_hit),
    .byte_edge  (byte_edge),
    .frame_edge (frame_edge),
    .searching  (searching)
  );

  sba_byte_out #(
    .BYTE_W (BYTE_W),
    .A2_VAL (A2_VAL)
  ) out_i (
    .clk        (clk),
    .rst        (rst),
    .byte_edge  (byte_edge),
    .frame_edge (frame_edge),
    .win_byte   (win_byte),
    .byte_out   (byte_out),
    .byte_stb   (byte_stb),
    .frame_sync (frame_sync)
  );

  AST_NO_STROBE_IN_RESET_EXIT: assert property (@(posedge clk)
    $past(rst) |-> !byte_stb && !frame_sync); // R9
endmodule

// File: tb/sonet_byte_aligner_tb.sv
module sonet_byte_aligner_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_bit = 1'b0;
  logic       oof_req = 1'b0;
  logic       hold_align = 1'b0;
  logic [7:0] byte_out;
  logic       byte_stb;
  logic       frame_sync;

  localparam logic [7:0] A1 = 8'hF6;
  localparam logic [7:0] A2 = 8'h28;

  // {expected sync with this byte, byte sent}
  localparam logic [8:0] VEC [0:14] = '{
    9'h055, 9'h0F6, 9'h0F6, 9'h0F6, 9'h028, 9'h028, 9'h128,
    9'h03C, 9'h0F6, 9'h0F6, 9'h0F6, 9'h028, 9'h028, 9'h128, 9'h0A5
  };

  always #10 clk = ~clk;

  sonet_byte_aligner dut_i (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .oof_req(oof_req),
    .hold_align(hold_align), .byte_out(byte_out), .byte_stb(byte_stb),
    .frame_sync(frame_sync)
  );

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  int   log_n = 0;
  logic [7:0] byte_log [0:511];
  logic       sync_log [0:511];
  int   sync_cnt = 0;
  int   last_sync_idx = 0;
  int   run = 0;
  int   last_run = 0;
  int   cyc = 0;
  int   last_stb_cyc = 0;
  bit   gap_en = 0;
  bit   gap_bad = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      run = 0;
    end else begin
      if (byte_stb) begin
        if (log_n < 512) begin
          byte_log[log_n] = byte_out;
          sync_log[log_n] = frame_sync;
        end
        if (frame_sync) begin
          sync_cnt++;
          last_sync_idx = log_n;
        end
        if (gap_en && (cyc - last_stb_cyc) != 8) gap_bad = 1;
        last_stb_cyc = cyc;
        log_n++;
      end
      if (frame_sync) run++;
      else if (run > 0) begin
        last_run = run;
        run = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rx_bit = b;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic send_zero_bits(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  task automatic send_frame();
    for (int i = 0; i < 3; i++) send_byte(A1);
    for (int i = 0; i < 3; i++) send_byte(A2);
  endtask

  initial begin
    int base;
    int sc;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(byte_out == 8'h00, "R9", "byte_out in reset", byte_out, 0);
    check(byte_stb == 1'b0, "R9", "byte_stb in reset", byte_stb, 0);
    check(frame_sync == 1'b0, "R9", "frame_sync in reset", frame_sync, 0);

    // Phase A: locked at offset 0 from reset; R1 R2 R3 R4 table walk
    rst = 1'b0;
    for (int k = 0; k < 15; k++) begin
      send_byte(VEC[k][7:0]);
      if (k == 0) gap_en = 1;
    end
    send_byte(8'h00);
    #1;
    for (int k = 0; k < 15; k++) begin
      check(byte_log[k+1] == VEC[k][7:0], "R1", "byte order MSB first",
            byte_log[k+1], VEC[k][7:0]);
      check(sync_log[k+1] == VEC[k][8], "R3", "sync only on final A2",
            sync_log[k+1], VEC[k][8]);
    end
    check(!gap_bad, "R2", "strobe every 8 clocks", gap_bad, 0);
    check(last_run == 8, "R4", "sync width in clocks", last_run, 8);

    // Phase B: frame at bit offset 3, no request -> no sync (R7)
    send_zero_bits(3);
    gap_en = 0;
    send_frame();
    for (int i = 0; i < 8; i++) send_byte(8'h00);
    #1;
    check(sync_cnt == 2, "R7", "no sync off boundary", sync_cnt, 2);

    // Phase C: oof rising edge, search finds offset 3 (R6), oof kept high (R4)
    oof_req = 1'b1;
    send_frame();
    send_byte(8'h55);
    send_byte(8'hAA);
    send_byte(8'h00);
    #1;
    check(sync_cnt == 3, "R6", "sync on relock", sync_cnt, 3);
    check(byte_log[last_sync_idx] == A2, "R6", "relock byte",
          byte_log[last_sync_idx], A2);
    check(byte_log[last_sync_idx+1] == 8'h55, "R6", "first byte after relock",
          byte_log[last_sync_idx+1], 8'h55);
    check(byte_log[last_sync_idx+2] == 8'hAA, "R6", "second byte after relock",
          byte_log[last_sync_idx+2], 8'hAA);
    check(last_run == 8, "R4", "sync width with oof high", last_run, 8);

    // Phase D: oof steady high, frame shifted by 2 -> no relock (R5)
    send_zero_bits(2);
    send_frame();
    for (int i = 0; i < 8; i++) send_byte(8'h00);
    #1;
    check(sync_cnt == 3, "R5", "steady oof does not search", sync_cnt, 3);
    send_zero_bits(6);
    send_frame();
    send_byte(8'h00);
    send_byte(8'h00);
    #1;
    check(sync_cnt == 4, "R4", "sync on boundary with oof high", sync_cnt, 4);
    check(byte_log[last_sync_idx+1] == 8'h00, "R5", "boundary kept",
          byte_log[last_sync_idx+1], 8'h00);

    // Phase E: hold_align suppresses search (R8)
    oof_req = 1'b0;
    send_byte(8'h00);
    hold_align = 1'b1;
    oof_req = 1'b1;
    send_zero_bits(1);
    send_frame();
    for (int i = 0; i < 8; i++) send_byte(8'h00);
    #1;
    check(sync_cnt == 4, "R8", "no lock while held", sync_cnt, 4);
    oof_req = 1'b0;
    hold_align = 1'b0;
    send_zero_bits(7);
    send_frame();
    send_byte(8'h00);
    send_byte(8'h00);
    #1;
    sc = sync_cnt;
    check(sc == 5, "R8", "boundary held after hold", sc, 5);

    // Phase F: reset mid-stream returns boundary to first bit (R9)
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(byte_stb == 1'b0, "R9", "byte_stb after reset", byte_stb, 0);
    check(byte_out == 8'h00, "R9", "byte_out after reset", byte_out, 0);
    check(frame_sync == 1'b0, "R9", "frame_sync after reset", frame_sync, 0);
    #1;
    base = log_n;
    @(negedge clk);
    rst = 1'b0;
    send_frame();
    send_byte(8'h00);
    #1;
    check(sync_log[base+6] == 1'b1, "R9", "offset 0 after reset",
          sync_log[base+6], 1);
    check(byte_log[base+1] == A1, "R9", "first byte after reset",
          byte_log[base+1], A1);
    check(sync_cnt == 6, "R3", "sync count total", sync_cnt, 6);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule